// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block decides, cycle by cycle, when a small 8-bit processor core stops its instruction stream to service a timer overflow, and then drives the entry sequence. The core tells the block when each instruction starts and how many cycles it takes (one or two). The block keeps its own 8-bit free-running timer, which raises a request each time it wraps. A request is taken only at the last cycle of an instruction, and only while interrupts are globally enabled. A request that lands in the first cycle of a two-cycle instruction therefore waits one extra cycle.

After acceptance the block spends two cycles writing the return address to a stack port, low byte first. It then loads the program counter with the vector word and allows one fetch cycle. If the vector slot holds a relative jump rather than the handler code itself, two further cycles pass. A one-cycle pulse marks the first handler cycle. Acceptance clears the global enable. Either of two strobes, one for enabling and one for returning from a handler, sets it again. While the entry runs, `busy` tells the core to issue nothing.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset `tmr_count` is 0 and it advances by one every clock, wrapping from 255 to 0. The cycle in which it reads 255 is the overflow cycle, so a request arises every 256 clocks.
- R2: A request is accepted in cycle `a` only if all of these hold in that cycle: `a` is an instruction boundary, `gie` is 1, and the block is idle. A boundary is the cycle with `op_start`=1 and `op_len`=1, or the cycle after a cycle with `op_start`=1 and `op_len`=2.
- R3: `gie` resets to 0. A pulse on `ie_set` or `ie_ret` in cycle c makes `gie` 1 from cycle c+1. Acceptance in cycle `a` makes `gie` 0 from `a`+1, and this wins over a strobe in the same cycle.
- R4: In cycle `a`+1, `stk_we` is 1, `stk_data` holds bits 7:0 of the `next_pc` sampled in cycle `a`, and `stk_addr` holds the stack pointer. In cycle `a`+2, `stk_data` holds bits 15:8 and `stk_addr` is one lower. The pointer starts at SP_TOP and drops by one after each write, wrapping modulo 2^SP_W.
- R5: In cycle `a`+3, `pc_load` is 1 and `pc_vec` equals VEC_BASE + VEC_IDX, the one-word slot of this source.
- R6: `busy` is 1 in cycles `a`+1 through `a`+4 when `slot_jump` was 0 at acceptance, and through `a`+6 when it was 1. `handler_start` is a single-cycle pulse in the cycle after the last busy cycle.
- R7: When `gie` is 1 and nothing is pending or in progress at the overflow cycle, `tmr_count` at `handler_start` reads 4 if the overflow cycle is a boundary. It reads 5 if the overflow cycle is the first cycle of a two-cycle instruction. A relative jump in the slot adds 2 to either value.
- R8: An overflow sets a pending flag, and acceptance clears it. A request still pending when `gie` returns is accepted at the first boundary after that.
- R9: While `busy` is 1, `gie` stays 0 and no further request is accepted. An overflow during entry stays pending.
- R10: During reset `busy`, `gie`, `stk_we`, `pc_load` and `handler_start` are 0 and `tmr_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one core cycle per period |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_start | input | 1 | First cycle of a new instruction |
| op_len | input | LEN_W | Cycle count of the instruction starting now (1 or 2) |
| next_pc | input | PC_W | Word address of the next unexecuted instruction |
| ie_set | input | 1 | Strobe that enables interrupts |
| ie_ret | input | 1 | Handler-return strobe that re-enables interrupts |
| slot_jump | input | 1 | 1 when the vector slot holds a relative jump |
| busy | output | 1 | Entry in progress; core must not issue |
| gie | output | 1 | Global interrupt enable state |
| tmr_count | output | TMR_W | Free-running timer value |
| stk_we | output | 1 | Stack byte write strobe |
| stk_addr | output | SP_W | Stack write address |
| stk_data | output | 8 | Stack write byte |
| pc_load | output | 1 | Program counter load strobe |
| pc_vec | output | PC_W | Vector word address |
| handler_start | output | 1 | First cycle of the handler |

## Verification
The timer wrap and the instruction boundary can fall in the same cycle, and only then is the request taken with no wait. When the wrap instead lands in the first cycle of a two-cycle instruction, acceptance slips by one cycle. The bench drives streams of one-cycle, two-cycle and mixed instructions whose phase relative to the wrap shifts on every trial. It reads the timer at the handler-start pulse and expects 4 or 5, plus 2 when a jump sits in the slot. The enable strobe and a pending request can also meet. Some trials delay re-enabling past a wrap, so the bench can confirm the pending request is taken at the next boundary.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_PUSH_LO = 3'd1,
    ST_PUSH_HI = 3'd2,
    ST_LOAD    = 3'd3,
    ST_FETCH   = 3'd4,
    ST_HOP1    = 3'd5,
    ST_HOP2    = 3'd6
  } ent_state_t;

  // word address of a vector slot: one word per source
  function automatic int unsigned vector_word(int unsigned base, int unsigned idx);
    return base + idx;
  endfunction

  // byte of the return address sent on a given push
  function automatic logic [7:0] ret_byte(logic [15:0] pc, logic upper);
    return upper ? pc[15:8] : pc[7:0];
  endfunction

endpackage

// File: rtl/ovf_timer.sv
module ovf_timer #(
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [TMR_W-1:0] count,
  output logic             wrap
);
  logic [TMR_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + TMR_W'(1);
  end

  assign count = cnt_q;
  assign wrap  = &cnt_q;
endmodule

// File: rtl/op_boundary.sv
module op_boundary #(
  parameter int LEN_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_start,
  input  logic [LEN_W-1:0] op_len,
  output logic             bnd
);
  logic [LEN_W-1:0] rem_q;
  logic [LEN_W-1:0] rem_d;

  always_comb begin
    if (op_start) begin
      bnd   = (op_len <= LEN_W'(1));
      rem_d = (op_len > LEN_W'(1)) ? op_len - LEN_W'(1) : '0;
    end else begin
      bnd   = (rem_q == LEN_W'(1));
      rem_d = (rem_q != '0) ? rem_q - LEN_W'(1) : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rem_q <= '0;
    else        rem_q <= rem_d;
  end
endmodule

// File: rtl/entry_fsm.sv
module entry_fsm
  import irq_seq_pkg::*;
#(
  parameter int          PC_W     = 16,
  parameter int          SP_W     = 8,
  parameter int          SP_TOP   = 255,
  parameter int unsigned VEC_WORD = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc,
  input  logic            slot_jump,
  input  logic [PC_W-1:0] next_pc,
  output logic            busy,
  output logic            stk_we,
  output logic [SP_W-1:0] stk_addr,
  output logic [7:0]      stk_data,
  output logic            pc_load,
  output logic [PC_W-1:0] pc_vec,
  output logic            handler_start
);
  ent_state_t      st_q, st_d;
  logic [PC_W-1:0] ret_q;
  logic            hop_q;
  logic [SP_W-1:0] sp_q;
  logic            hs_q;

  always_comb begin
    case (st_q)
      ST_IDLE:    st_d = acc ? ST_PUSH_LO : ST_IDLE;
      ST_PUSH_LO: st_d = ST_PUSH_HI;
      ST_PUSH_HI: st_d = ST_LOAD;
      ST_LOAD:    st_d = ST_FETCH;
      ST_FETCH:   st_d = hop_q ? ST_HOP1 : ST_IDLE;
      ST_HOP1:    st_d = ST_HOP2;
      default:    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      ret_q <= '0;
      hop_q <= 1'b0;
      sp_q  <= SP_W'(SP_TOP);
      hs_q  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (acc) begin
        ret_q <= next_pc;
        hop_q <= slot_jump;
      end
      if (stk_we) sp_q <= sp_q - SP_W'(1);
      hs_q <= ((st_q == ST_FETCH) && !hop_q) || (st_q == ST_HOP2);
    end
  end

  assign busy          = (st_q != ST_IDLE);
  assign stk_we        = (st_q == ST_PUSH_LO) || (st_q == ST_PUSH_HI);
  assign stk_addr      = sp_q;
  assign stk_data      = ret_byte(16'(ret_q), st_q == ST_PUSH_HI);
  assign pc_load       = (st_q == ST_LOAD);
  assign pc_vec        = PC_W'(VEC_WORD);
  assign handler_start = hs_q;
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int PC_W     = 16,
  parameter int SP_W     = 8,
  parameter int SP_TOP   = 255,
  parameter int TMR_W    = 8,
  parameter int LEN_W    = 2,
  parameter int VEC_BASE = 0,
  parameter int VEC_IDX  = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_start,
  input  logic [LEN_W-1:0] op_len,
  input  logic [PC_W-1:0]  next_pc,
  input  logic             ie_set,
  input  logic             ie_ret,
  input  logic             slot_jump,
  output logic             busy,
  output logic             gie,
  output logic [TMR_W-1:0] tmr_count,
  output logic             stk_we,
  output logic [SP_W-1:0]  stk_addr,
  output logic [7:0]       stk_data,
  output logic             pc_load,
  output logic [PC_W-1:0]  pc_vec,
  output logic             handler_start
);
  localparam int unsigned VEC_WORD = vector_word(VEC_BASE, VEC_IDX);

  // named internal events, observed by the bound checker
  logic wrap_w;
  logic bnd_w;
  logic req_w;
  logic acc_w;
  logic gie_q;
  logic pend_q;

  ovf_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .count (tmr_count),
    .wrap  (wrap_w)
  );

  op_boundary #(.LEN_W(LEN_W)) u_bnd (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_start (op_start),
    .op_len   (op_len),
    .bnd      (bnd_w)
  );

  assign req_w = pend_q | wrap_w;
  assign acc_w = bnd_w & gie_q & req_w & ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (acc_w)                gie_q <= 1'b0;
      else if (ie_set | ie_ret) gie_q <= 1'b1;
      if (acc_w)       pend_q <= 1'b0;
      else if (wrap_w) pend_q <= 1'b1;
    end
  end

  assign gie = gie_q;

  entry_fsm #(
    .PC_W     (PC_W),
    .SP_W     (SP_W),
    .SP_TOP   (SP_TOP),
    .VEC_WORD (VEC_WORD)
  ) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .acc           (acc_w),
    .slot_jump     (slot_jump),
    .next_pc       (next_pc),
    .busy          (busy),
    .stk_we        (stk_we),
    .stk_addr      (stk_addr),
    .stk_data      (stk_data),
    .pc_load       (pc_load),
    .pc_vec        (pc_vec),
    .handler_start (handler_start)
  );
endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk #(
  parameter int PC_W  = 16,
  parameter int SP_W  = 8,
  parameter int TMR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc,
  input logic             gie,
  input logic             busy,
  input logic             stk_we,
  input logic [SP_W-1:0]  stk_addr,
  input logic [7:0]       stk_data,
  input logic             pc_load,
  input logic             handler_start,
  input logic [PC_W-1:0]  next_pc,
  input logic [TMR_W-1:0] tmr_count
);
  logic live;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;
  end

  p_tmr_step_r1: assert property (@(posedge clk) disable iff (!rst_n || !live)
    tmr_count == TMR_W'($past(tmr_count) + 1'b1));

  p_gie_clear_r3: assert property (@(posedge clk) disable iff (!rst_n || !live)
    acc |=> !gie);

  p_push_lo_r4: assert property (@(posedge clk) disable iff (!rst_n || !live)
    acc |=> (stk_we && stk_data == $past(next_pc[7:0])));

  p_push_hi_r4: assert property (@(posedge clk) disable iff (!rst_n || !live)
    $rose(stk_we) |=> (stk_we && stk_addr == SP_W'($past(stk_addr) - 1'b1)
                       && stk_data == $past(next_pc[15:8], 2)));

  p_load_after_push_r5: assert property (@(posedge clk) disable iff (!rst_n || !live)
    $fell(stk_we) |-> pc_load);

  p_hs_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n || !live)
    handler_start |=> !handler_start);

  p_hs_after_busy_r6: assert property (@(posedge clk) disable iff (!rst_n || !live)
    handler_start |-> (!busy && $past(busy)));

  p_gie_low_busy_r9: assert property (@(posedge clk) disable iff (!rst_n || !live)
    busy |-> !gie);
endmodule

bind irq_entry_seq irq_entry_chk #(
  .PC_W  (PC_W),
  .SP_W  (SP_W),
  .TMR_W (TMR_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .acc           (acc_w),
  .gie           (gie),
  .busy          (busy),
  .stk_we        (stk_we),
  .stk_addr      (stk_addr),
  .stk_data      (stk_data),
  .pc_load       (pc_load),
  .handler_start (handler_start),
  .next_pc       (next_pc),
  .tmr_count     (tmr_count)
);

// File: tb/sim_irq_entry_seq.sv
module sim_irq_entry_seq;
  localparam int PC_W  = 16;
  localparam int SP_W  = 8;
  localparam int LEN_W = 2;
  localparam int TMR_W = 8;
  localparam int VB    = 32;
  localparam int VI    = 5;
  localparam int SPT   = 240;
  localparam int NCYC  = 256 * 28;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             op_start, ie_set, ie_ret, slot_jump;
  logic [LEN_W-1:0] op_len;
  logic [PC_W-1:0]  next_pc;
  logic             busy, gie, stk_we, pc_load, handler_start;
  logic [TMR_W-1:0] tmr_count;
  logic [SP_W-1:0]  stk_addr;
  logic [7:0]       stk_data;
  logic [PC_W-1:0]  pc_vec;

  always #10 clk = ~clk;

  irq_entry_seq #(
    .PC_W(PC_W), .SP_W(SP_W), .SP_TOP(SPT), .TMR_W(TMR_W),
    .LEN_W(LEN_W), .VEC_BASE(VB), .VEC_IDX(VI)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_len(op_len),
    .next_pc(next_pc), .ie_set(ie_set), .ie_ret(ie_ret), .slot_jump(slot_jump),
    .busy(busy), .gie(gie), .tmr_count(tmr_count), .stk_we(stk_we),
    .stk_addr(stk_addr), .stk_data(stk_data), .pc_load(pc_load),
    .pc_vec(pc_vec), .handler_start(handler_start)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  task automatic chk(string req, string what, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // reference state, derived from the requirements
  int acc_c = -100, jmp_m = 0, sp_m = SPT, sp_at = 0, ret_m = 0;
  bit gie_m = 0, pend_m = 0;
  int rem_b = 0, cur_len = 1, pc_nxt = 0, n_ins = 0, trial = 0;
  int ret_at = 3;
  bit ret_use_set = 1;
  bit land_ok = 0, land_two = 0, from_pend = 0;
  int n4 = 0, n5 = 0, n_late = 0;

  function automatic int pick();
    int mode = trial % 6;
    if (mode == 4) return 2;
    if (mode == 5) return 1;
    return (((n_ins * (trial % 7 + 1)) + trial) % 3 == 0) ? 2 : 1;
  endfunction

  task automatic step(int c);
    int  d, lat, ln;
    bit  bnd, acc, busy_e, wrapc;
    d      = c - acc_c;
    busy_e = (d >= 1) && (d <= 4 + 2 * jmp_m);
    chk("R1", "timer", tmr_count, c % 256);
    chk("R6", "busy", busy, busy_e);
    chk("R3", "gie", gie, gie_m);
    if (busy_e) chk("R9", "gie low in entry", gie, 0);
    chk("R2", "stack write (acceptance)", stk_we, (d == 1 || d == 2));
    if (d == 1) begin
      chk("R4", "low byte", stk_data, ret_m % 256);
      chk("R4", "low addr", stk_addr, sp_at);
    end
    if (d == 2) begin
      chk("R4", "high byte", stk_data, (ret_m / 256) % 256);
      chk("R4", "high addr", stk_addr, (sp_at + 255) % 256);
    end
    chk("R5", "pc load", pc_load, d == 3);
    if (d == 3) chk("R5", "vector", pc_vec, VB + VI);
    chk("R6", "handler start", handler_start, d == 5 + 2 * jmp_m);
    if (d == 5 + 2 * jmp_m) begin
      if (land_ok) begin
        lat = (land_two ? 5 : 4) + 2 * jmp_m;
        chk("R7", "overflow latency", tmr_count, lat);
        if (land_two) n5++; else n4++;
        land_ok = 0;
      end
      if (from_pend) n_late++;
      trial++;
      pc_nxt      = (jmp_m != 0) ? 'h300 : VB + VI;
      slot_jump   = ((trial >> 1) & 1) != 0;
      ret_use_set = (trial % 2) != 0;
      ret_at      = (trial % 4 == 3) ? c + 255 : c + 3 + trial % 5;
    end
    ie_set = (c == ret_at) && ret_use_set;
    ie_ret = (c == ret_at) && !ret_use_set;
    op_start = 1'b0;
    op_len   = LEN_W'(1);
    bnd      = 0;
    if (!busy_e) begin
      if (rem_b > 0) begin
        bnd = (rem_b == 1);
        rem_b--;
      end else begin
        ln       = pick();
        cur_len  = ln;
        op_start = 1'b1;
        op_len   = LEN_W'(ln);
        next_pc  = PC_W'(pc_nxt + 1);
        pc_nxt++;
        bnd      = (ln == 1);
        rem_b    = ln - 1;
        n_ins++;
      end
    end
    wrapc = (c % 256) == 255;
    if (wrapc) begin
      land_ok  = gie_m && !pend_m && !busy_e;
      land_two = op_start && (cur_len == 2);
    end
    acc = bnd && gie_m && (pend_m || wrapc) && !busy_e;
    if (acc) begin
      acc_c     = c;
      jmp_m     = slot_jump ? 1 : 0;
      sp_at     = sp_m;
      sp_m      = (sp_m + 254) % 256;
      ret_m     = next_pc;
      from_pend = pend_m && !land_ok;
      pend_m    = 0;
      gie_m     = 0;
    end else begin
      pend_m = pend_m || wrapc;
      gie_m  = gie_m || ie_set || ie_ret;
    end
  endtask

  initial begin
    op_start = 0; op_len = LEN_W'(1); next_pc = '0;
    ie_set = 0; ie_ret = 0; slot_jump = 0;
    repeat (3) @(negedge clk);
    chk("R10", "reset busy", busy, 0);
    chk("R10", "reset gie", gie, 0);
    chk("R10", "reset stk_we", stk_we, 0);
    chk("R10", "reset pc_load", pc_load, 0);
    chk("R10", "reset handler_start", handler_start, 0);
    chk("R10", "reset timer", tmr_count, 0);
    rst_n = 1'b1;
    for (int c = 0; c < NCYC; c++) begin
      step(c);
      @(negedge clk);
    end
    chk("R7", "both landing kinds seen", (n4 > 0) && (n5 > 0), 1);
    chk("R8", "late pending request taken", n_late > 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    done = 1;
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule